// File: doc/BRIEF.md
# Handshaked Trigger Event Channel

This block moves one debug trigger event from a sending clock domain into a receiving clock domain. A rising event on the sender side becomes a level on `trig_out` in the receiver domain. That level stays high until the receiver acknowledges it, either through a hardware acknowledge pin or through a software acknowledge strobe. The acknowledge travels back to the sender through a four-phase request/acknowledge loop. Only when that loop has fully closed does the sender accept a fresh event. Any events that show up while the loop is still open fold into the one that is pending.

Two static straps adapt the channel to its surroundings.

- With the handshake strap high, the loop is removed. The output then simply reproduces the (registered) event level, so back-to-back pulses pass through one by one and no acknowledge is needed.
- With the synchronizer strap high, the register chain into the receiver domain is skipped. This shortens latency when both clocks are synchronous.

Top module: `trig_handshake_chan`

## Requirements
- R1: While reset is high and in the first cycle after it, `trig_out` and `ack_seen` are 0.
- R2: Only a 0-to-1 transition of the (registered) `evt_in` level starts an event. A low level is idle. An input held high for many cycles produces exactly one output event.
- R3: With `hs_byp`=0, once `trig_out` is high it stays high on every receiver edge where no acknowledge is sampled. This holds for any length of wait, and it holds when an earlier acknowledge pulse has already been removed.
- R4: With `hs_byp`=0, `hw_ack` sampled high while `trig_out` is high clears `trig_out` at that receiver edge.
- R5: With `hs_byp`=0 and `SW_ACK_EN`=1, `sw_ack` sampled high while `trig_out` is high clears `trig_out` at that edge, in the same way as R4.
- R6: An acknowledge sampled while `trig_out` is low has no effect. A later event still raises `trig_out`, and `trig_out` then waits for a new acknowledge.
- R7: Events that arrive after an accepted event and before the handshake has returned to idle merge into that event. They produce no further output event.
- R8: After an acknowledge, `ack_seen` rises and later falls again (four-phase return). The sender holds its request until the returned acknowledge is seen, and the receiver raises `trig_out` only on a pending request.
- R9: With `hs_byp`=1, `trig_out` reproduces the event level pulse for pulse. Single-cycle pulses come out with the same latency as R11, no acknowledge is needed, and `ack_seen` stays 0.
- R10: With `sync_byp`=1, the receiver-side chain is skipped. `trig_out` rises `INPUT_REG`+2 receiver edges after `evt_in` is first sampled high.
- R11: With `sync_byp`=0, `trig_out` rises `INPUT_REG`+`SYNC_STAGES`+2 edges after `evt_in` is first sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| snd_clk | input | 1 | Sender domain clock |
| snd_rst | input | 1 | Sender domain synchronous reset, active high |
| evt_in | input | 1 | Raw event level, high means event |
| ack_seen | output | 1 | Acknowledge returned to sender domain (registered) |
| rcv_clk | input | 1 | Receiver domain clock |
| rcv_rst | input | 1 | Receiver domain synchronous reset, active high |
| hw_ack | input | 1 | Hardware acknowledge from receiver |
| sw_ack | input | 1 | Software acknowledge strobe from receiver |
| trig_out | output | 1 | Trigger level toward receiver (registered) |
| hs_byp | input | 1 | Strap: 1 removes the request/acknowledge loop |
| sync_byp | input | 1 | Strap: 1 skips the receiver-side synchronizer |

## Verification
The bench builds the channel with its defaults: `SYNC_STAGES`=2, `INPUT_REG`=1 and `SW_ACK_EN`=1. It drives both domains from one clock. Because the two domains share that clock, the exact edge counts of R10 and R11 can be sampled deterministically. The same setup lets the bypass output be compared pulse by pulse against the driven event pattern. The full four-phase round trip still runs through both two-stage chains, so the merge window, the stray-acknowledge case and a short acknowledge pulse are all exercised through the real return path.

// File: rtl/thc_pkg.sv
`timescale 1ns/1ps
package thc_pkg;
  // sender handshake phases
  typedef enum logic [1:0] {
    SND_IDLE  = 2'd0,
    SND_WAIT  = 2'd1,
    SND_DRAIN = 2'd2
  } snd_state_t;
endpackage

// File: rtl/thc_sync.sv
`timescale 1ns/1ps
// Multi-stage level synchronizer with a static bypass.
module thc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  input  logic byp,
  output logic q
);
  logic [STAGES-1:0] chain;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= 1'b0;
        else     chain[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= 1'b0;
        else     chain[i] <= chain[i-1];
      end
    end
  end

  assign q = byp ? d : chain[STAGES-1];
endmodule

// File: rtl/thc_sender.sv
`timescale 1ns/1ps
// Sender side: input register, edge detection and request control.
module thc_sender
  import thc_pkg::*;
#(
  parameter bit INPUT_REG = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic evt_raw,
  input  logic hs_byp,
  input  logic ack_back,
  output logic req,
  output logic ack_seen
);
  logic       evt_q;
  logic       evt_prev;
  logic       evt_edge;
  logic       req_nx;
  snd_state_t st, st_nx;

  if (INPUT_REG) begin : g_inreg
    always_ff @(posedge clk) begin
      if (rst) evt_q <= 1'b0;
      else     evt_q <= evt_raw;
    end
  end else begin : g_noreg
    assign evt_q = evt_raw;
  end

  always_ff @(posedge clk) begin
    if (rst) evt_prev <= 1'b0;
    else     evt_prev <= evt_q;
  end

  assign evt_edge = evt_q & ~evt_prev;

  always_comb begin
    st_nx  = st;
    req_nx = req;
    unique case (st)
      SND_IDLE: begin
        if (evt_edge) begin
          req_nx = 1'b1;
          st_nx  = SND_WAIT;
        end
      end
      SND_WAIT: begin
        if (ack_back) begin
          req_nx = 1'b0;
          st_nx  = SND_DRAIN;
        end
      end
      SND_DRAIN: begin
        if (!ack_back) st_nx = SND_IDLE;
      end
      default: begin
        st_nx  = SND_IDLE;
        req_nx = 1'b0;
      end
    endcase
    if (hs_byp) begin
      st_nx  = SND_IDLE;
      req_nx = evt_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= SND_IDLE;
      req      <= 1'b0;
      ack_seen <= 1'b0;
    end else begin
      st       <= st_nx;
      req      <= req_nx;
      ack_seen <= ack_back & ~hs_byp;
    end
  end
endmodule

// File: rtl/thc_receiver.sv
`timescale 1ns/1ps
// Receiver side: holds the trigger level until acknowledged.
module thc_receiver #(
  parameter bit SW_ACK_EN = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic req_in,
  input  logic hs_byp,
  input  logic hw_ack,
  input  logic sw_ack,
  output logic trig,
  output logic ack_ret
);
  logic ack_any;

  if (SW_ACK_EN) begin : g_sw
    assign ack_any = hw_ack | sw_ack;
  end else begin : g_hw_only
    logic unused_sw;
    assign unused_sw = sw_ack;
    assign ack_any   = hw_ack;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trig    <= 1'b0;
      ack_ret <= 1'b0;
    end else if (hs_byp) begin
      trig    <= req_in;
      ack_ret <= 1'b0;
    end else if (!trig && !ack_ret && req_in) begin
      trig <= 1'b1;
    end else if (trig && ack_any) begin
      trig    <= 1'b0;
      ack_ret <= 1'b1;
    end else if (ack_ret && !req_in) begin
      ack_ret <= 1'b0;
    end
  end
endmodule

// File: rtl/trig_handshake_chan.sv
`timescale 1ns/1ps
// Top: one trigger event channel between two clock domains.
module trig_handshake_chan #(
  parameter int SYNC_STAGES = 2,
  parameter bit INPUT_REG   = 1'b1,
  parameter bit SW_ACK_EN   = 1'b1
) (
  input  logic snd_clk,
  input  logic snd_rst,
  input  logic evt_in,
  output logic ack_seen,
  input  logic rcv_clk,
  input  logic rcv_rst,
  input  logic hw_ack,
  input  logic sw_ack,
  output logic trig_out,
  input  logic hs_byp,
  input  logic sync_byp
);
  logic req_line;
  logic req_at_rcv;
  logic ack_ret;
  logic ack_back;

  thc_sender #(.INPUT_REG(INPUT_REG)) u_snd (
    .clk      (snd_clk),
    .rst      (snd_rst),
    .evt_raw  (evt_in),
    .hs_byp   (hs_byp),
    .ack_back (ack_back),
    .req      (req_line),
    .ack_seen (ack_seen)
  );

  thc_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk (rcv_clk),
    .rst (rcv_rst),
    .d   (req_line),
    .byp (sync_byp),
    .q   (req_at_rcv)
  );

  thc_receiver #(.SW_ACK_EN(SW_ACK_EN)) u_rcv (
    .clk     (rcv_clk),
    .rst     (rcv_rst),
    .req_in  (req_at_rcv),
    .hs_byp  (hs_byp),
    .hw_ack  (hw_ack),
    .sw_ack  (sw_ack),
    .trig    (trig_out),
    .ack_ret (ack_ret)
  );

  // return path always synchronized: it is the four-phase loop
  thc_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk (snd_clk),
    .rst (snd_rst),
    .d   (ack_ret),
    .byp (1'b0),
    .q   (ack_back)
  );
endmodule

// File: rtl/thc_checker.sv
`timescale 1ns/1ps
module thc_checker #(
  parameter bit SW_ACK_EN = 1'b1
) (
  input logic snd_clk,
  input logic snd_rst,
  input logic rcv_clk,
  input logic rcv_rst,
  input logic hs_byp,
  input logic hw_ack,
  input logic sw_ack,
  input logic trig_out,
  input logic ack_seen,
  input logic req_line,
  input logic req_at_rcv,
  input logic ack_back
);
  AST_TRIG_HOLD: assert property (@(posedge rcv_clk) disable iff (rcv_rst)
    (!hs_byp && trig_out && !hw_ack && !(SW_ACK_EN && sw_ack)) |=> trig_out); // R3

  AST_HW_ACK_CLEAR: assert property (@(posedge rcv_clk) disable iff (rcv_rst)
    (!hs_byp && trig_out && hw_ack) |=> !trig_out); // R4

  if (SW_ACK_EN) begin : g_sw_chk
    AST_SW_ACK_CLEAR: assert property (@(posedge rcv_clk) disable iff (rcv_rst)
      (!hs_byp && trig_out && sw_ack) |=> !trig_out); // R5
  end

  AST_RAISE_ON_REQ: assert property (@(posedge rcv_clk) disable iff (rcv_rst)
    (!hs_byp && !trig_out && !req_at_rcv) |=> !trig_out); // R8

  AST_REQ_HOLD: assert property (@(posedge snd_clk) disable iff (snd_rst)
    (!hs_byp && req_line && !ack_back) |=> req_line); // R8

  AST_BYP_FOLLOW: assert property (@(posedge rcv_clk) disable iff (rcv_rst)
    hs_byp |=> (trig_out == $past(req_at_rcv))); // R9

  AST_BYP_NO_ACK: assert property (@(posedge snd_clk) disable iff (snd_rst)
    hs_byp |=> !ack_seen); // R9
endmodule

bind trig_handshake_chan thc_checker #(.SW_ACK_EN(SW_ACK_EN)) u_chk (
  .snd_clk    (snd_clk),
  .snd_rst    (snd_rst),
  .rcv_clk    (rcv_clk),
  .rcv_rst    (rcv_rst),
  .hs_byp     (hs_byp),
  .hw_ack     (hw_ack),
  .sw_ack     (sw_ack),
  .trig_out   (trig_out),
  .ack_seen   (ack_seen),
  .req_line   (req_line),
  .req_at_rcv (req_at_rcv),
  .ack_back   (ack_back)
);

// File: tb/trig_handshake_chan_test.sv
`timescale 1ns/1ps
module trig_handshake_chan_test;
  localparam int SYNC_STAGES = 2;
  localparam int INPUT_REG   = 1;
  localparam int LAT_SYNC    = INPUT_REG + SYNC_STAGES + 2;
  localparam int LAT_BYP     = INPUT_REG + 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic evt_in = 1'b0;
  logic hw_ack = 1'b0;
  logic sw_ack = 1'b0;
  logic hs_byp = 1'b0;
  logic sync_byp = 1'b0;
  logic ack_seen, trig_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  trig_handshake_chan #(.SYNC_STAGES(SYNC_STAGES), .INPUT_REG(INPUT_REG[0]),
                        .SW_ACK_EN(1'b1)) uut (
    .snd_clk(clk), .snd_rst(rst), .evt_in(evt_in), .ack_seen(ack_seen),
    .rcv_clk(clk), .rcv_rst(rst), .hw_ack(hw_ack), .sw_ack(sw_ack),
    .trig_out(trig_out), .hs_byp(hs_byp), .sync_byp(sync_byp)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic do_reset(input logic hb, input logic sb);
    @(negedge clk);
    rst = 1'b1; evt_in = 1'b0; hw_ack = 1'b0; sw_ack = 1'b0;
    hs_byp = hb; sync_byp = sb;
    step(3);
    rst = 1'b0;
  endtask

  // waits for the returned acknowledge to rise and fall again
  task automatic close_loop(input string rq);
    int n;
    n = 0;
    while (!ack_seen && n < 30) begin step(1); n++; end
    chk(ack_seen == 1'b1, rq, ack_seen, 1);
    n = 0;
    while (ack_seen && n < 30) begin step(1); n++; end
    chk(ack_seen == 1'b0, rq, ack_seen, 0);
    step(2);
  endtask

  task automatic t_reset();
    do_reset(1'b0, 1'b0);
    chk(trig_out == 1'b0, "R1 trig after reset", trig_out, 0);
    chk(ack_seen == 1'b0, "R1 ack_seen after reset", ack_seen, 0);
    step(20);
    chk(trig_out == 1'b0, "R2 idle low input", trig_out, 0);
  endtask

  // single event, hardware acknowledge given as a one-cycle pulse
  task automatic t_hw_ack();
    do_reset(1'b0, 1'b0);
    evt_in = 1'b1; step(1); evt_in = 1'b0;
    step(LAT_SYNC - 2);
    chk(trig_out == 1'b0, "R11 not before latency", trig_out, 0);
    step(1);
    chk(trig_out == 1'b1, "R11 rise at latency", trig_out, 1);
    step(25);
    chk(trig_out == 1'b1, "R3 held without ack", trig_out, 1);
    hw_ack = 1'b1; step(1); hw_ack = 1'b0;
    chk(trig_out == 1'b0, "R4 hw ack clears", trig_out, 0);
    close_loop("R8 hw round trip");
    chk(trig_out == 1'b0, "R3 stays clear after short ack", trig_out, 0);
  endtask

  task automatic t_sw_ack();
    do_reset(1'b0, 1'b0);
    evt_in = 1'b1; step(1); evt_in = 1'b0;
    step(LAT_SYNC + 3);
    chk(trig_out == 1'b1, "R5 raised", trig_out, 1);
    sw_ack = 1'b1; step(1); sw_ack = 1'b0;
    chk(trig_out == 1'b0, "R5 sw ack clears", trig_out, 0);
    close_loop("R8 sw round trip");
  endtask

  task automatic t_stray_ack();
    do_reset(1'b0, 1'b0);
    hw_ack = 1'b1; step(2); hw_ack = 1'b0;
    evt_in = 1'b1; step(1); evt_in = 1'b0;
    step(LAT_SYNC + 5);
    chk(trig_out == 1'b1, "R6 stray ack ignored", trig_out, 1);
    hw_ack = 1'b1; step(1); hw_ack = 1'b0;
    chk(trig_out == 1'b0, "R6 later ack clears", trig_out, 0);
    close_loop("R6 round trip");
  endtask

  task automatic t_merge();
    int rises;
    logic prev;
    do_reset(1'b0, 1'b0);
    rises = 0; prev = 1'b0;
    for (int i = 0; i < 20; i++) begin
      evt_in = (i < 8) && (i % 2 == 0);
      step(1);
      if (trig_out && !prev) rises++;
      prev = trig_out;
    end
    evt_in = 1'b0;
    hw_ack = 1'b1; step(1); hw_ack = 1'b0;
    prev = trig_out;
    for (int i = 0; i < 25; i++) begin
      // extra pulse inside the return window must merge as well
      evt_in = (i == 2);
      step(1);
      if (trig_out && !prev) rises++;
      prev = trig_out;
    end
    chk(rises == 1, "R7 burst merged", rises, 1);
    chk(trig_out == 1'b0, "R7 no second event", trig_out, 0);
  endtask

  task automatic t_held();
    int rises;
    logic prev;
    do_reset(1'b0, 1'b0);
    rises = 0; prev = 1'b0;
    evt_in = 1'b1;
    for (int i = 0; i < 45; i++) begin
      hw_ack = (i == 12);
      step(1);
      if (trig_out && !prev) rises++;
      prev = trig_out;
    end
    hw_ack = 1'b0; evt_in = 1'b0;
    chk(rises == 1, "R2 held level single event", rises, 1);
    chk(trig_out == 1'b0, "R2 no retrigger", trig_out, 0);
    step(10);
  endtask

  task automatic t_sync_byp();
    do_reset(1'b0, 1'b1);
    evt_in = 1'b1; step(1); evt_in = 1'b0;
    step(LAT_BYP - 2);
    chk(trig_out == 1'b0, "R10 not before latency", trig_out, 0);
    step(1);
    chk(trig_out == 1'b1, "R10 rise at latency", trig_out, 1);
    hw_ack = 1'b1; step(1); hw_ack = 1'b0;
    chk(trig_out == 1'b0, "R10 ack clears", trig_out, 0);
    close_loop("R10 round trip");
  endtask

  task automatic t_hs_byp();
    logic v [0:39];
    int bad, rises, exp_rises, ack_hi;
    logic prev;
    do_reset(1'b1, 1'b0);
    bad = 0; rises = 0; exp_rises = 0; ack_hi = 0; prev = 1'b0;
    for (int i = 0; i < 40; i++) begin
      v[i] = (i < 30) && ((i % 4 == 0) || (i == 17) || (i == 18));
      if (v[i] && (i == 0 || !v[i-1])) exp_rises++;
    end
    for (int j = 0; j < 40; j++) begin
      evt_in = v[j];
      step(1);
      if (j >= LAT_SYNC - 1 && trig_out !== v[j-(LAT_SYNC-1)]) bad++;
      if (trig_out && !prev) rises++;
      prev = trig_out;
      if (ack_seen) ack_hi++;
    end
    evt_in = 1'b0;
    step(LAT_SYNC);
    chk(bad == 0, "R9 follows pulse pattern", bad, 0);
    chk(rises == exp_rises, "R9 multi-shot pulses", rises, exp_rises);
    chk(ack_hi == 0, "R9 ack_seen quiet", ack_hi, 0);
  endtask

  initial begin
    t_reset();
    t_hw_ack();
    t_sw_ack();
    t_stray_ack();
    t_merge();
    t_held();
    t_sync_byp();
    t_hs_byp();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule